// File: doc/BRIEF.md
# Quad Branch Predication Controller

This block steers the per-pixel execution mask of a shader unit that runs four pixels together as a quad on one shared instruction stream. The decoder reports each instruction's class (IF, ELSE, ENDIF or other) and, for an IF, a four-bit condition vector with one bit per pixel. The controller returns the active-lane mask for the instructions that follow.

The controller also reports when one side of a conditional can be skipped. If the lanes of the quad disagree on a condition, the fetch logic issues both sides to the whole quad, and each lane only keeps results from the side it selected. If no lane needs a side, the controller asks for that side to be skipped. Nested conditionals use a predicate stack of bounded depth, because per-lane predicate storage is taken from the temporary-register budget.

Instruction classes are encoded on `instr_kind` as follows: 2'b00 other, 2'b01 IF, 2'b10 ELSE, 2'b11 ENDIF. All outputs are registered. An instruction sampled at a rising edge is reflected on every output from that edge until the next one.

Top module: `quad_pred_ctrl`

## Requirements
- R1: After a synchronous active-low reset the lane mask is 4'b1111, the stack is empty, and skip_then, skip_else, both_paths, stack_ovf and stack_err are all 0.
- R2: An accepted IF replaces the lane mask with the previous mask ANDed with cond_bits, bit i being lane i. A lane that was already inactive stays inactive whatever its condition bit is.
- R3: skip_then is 1 for exactly the cycle after an accepted IF whose new mask is 4'b0000.
- R4: both_paths is 1 for exactly the cycle after an accepted IF for which some active lane has its condition set and some other active lane has it clear.
- R5: An ELSE with a non-empty stack sets the mask to (parent mask AND NOT condition) of the innermost entry. skip_else is 1 for the following cycle when that result is 4'b0000.
- R6: An ENDIF with a non-empty stack restores the parent mask of the innermost entry and pops that entry.
- R7: Up to 8 nested IFs are stacked, and each ENDIF restores the mask that was active before its own IF.
- R8: An IF arriving while 8 entries are stacked is not pushed and leaves the mask unchanged. stack_ovf is 1 for the following cycle, and skip_then and both_paths stay 0.
- R9: An ELSE or ENDIF arriving with an empty stack leaves the mask unchanged and pulses stack_err for one cycle.
- R10: A cycle with instr_valid low or with class "other" leaves the mask and the stack unchanged, and all flags are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction class is presented this cycle |
| instr_kind | input | 2 | 00 other, 01 IF, 10 ELSE, 11 ENDIF |
| cond_bits | input | 4 | Per-lane condition for an IF |
| lane_mask | output | 4 | Active lanes for the following instructions |
| skip_then | output | 1 | The THEN side is needed by no lane |
| skip_else | output | 1 | The ELSE side is needed by no lane |
| both_paths | output | 1 | The quad diverged; both sides will be issued |
| stack_ovf | output | 1 | An IF was refused because the stack was full |
| stack_err | output | 1 | ELSE or ENDIF arrived with no open IF |

## Verification
Two outcomes can collide in one cycle: a full-stack refusal and the skip and divergence decisions. The bench fills the stack to depth 8 and then sends an IF whose condition would empty the mask. The design must raise only stack_ovf, keep the mask, and leave the stack intact, which the eight ENDIFs that follow confirm by restoring each parent mask in turn. In the same way, an ELSE or ENDIF on an empty stack is checked for stack_err alone, with the mask held. Every operation is compared against a lane-mask model kept in the bench.

// File: rtl/quad_pred_pkg.sv
// Shared definitions for the quad predication controller.
// Assumes a quad of four lanes; the lane count is kept as a parameter so
// that the stack and evaluator stay width-generic.
package quad_pred_pkg;
    localparam int LANES = 4;

    // Instruction class seen by the controller.
    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_IF    = 2'b01,
        KIND_ELSE  = 2'b10,
        KIND_ENDIF = 2'b11
    } instr_kind_e;

    // One nesting level: mask in force before the IF and the IF condition.
    typedef struct packed {
        logic [LANES-1:0] parent;
        logic [LANES-1:0] cond;
    } pred_entry_t;
endpackage

// File: rtl/quad_pred_stack.sv
// Predicate stack for nested conditionals.
// Holds up to DEPTH entries. It presents the innermost entry at all times,
// together with full and empty. The caller must never push when full or
// pop when empty; such requests are ignored here.
module quad_pred_stack
    import quad_pred_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        pop,
    input  pred_entry_t push_entry,
    output pred_entry_t top_entry,
    output logic        full,
    output logic        empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pred_entry_t       mem [DEPTH];
    logic [CW-1:0]     depth;
    logic [AW-1:0]     top_idx;

    assign full    = (depth == CW'(DEPTH));
    assign empty   = (depth == '0);
    assign top_idx = empty ? '0 : AW'(depth - CW'(1));

    // Present the innermost entry.
    assign top_entry = mem[top_idx];

    // Track the number of stacked levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (push && !full) begin
            depth <= depth + CW'(1);
        end else if (pop && !empty) begin
            depth <= depth - CW'(1);
        end
    end

    // Store the pushed entry at the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push && !full) begin
            mem[AW'(depth)] <= push_entry;
        end
    end

    // R7: the level count never exceeds the storage.
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    // R7: a push grows the stack by one level.
    a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (depth == $past(depth) + CW'(1)));

    // R6: a pop shrinks the stack by one level.
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (depth == $past(depth) - CW'(1)));
endmodule

// File: rtl/quad_pred_eval.sv
// Combinational decision logic of the controller.
// From the instruction class, the current mask, the condition and the
// innermost stack entry, it computes the next mask, the stack operation
// and the one-cycle flags. It holds no state.
module quad_pred_eval
    import quad_pred_pkg::*;
(
    input  logic             valid,
    input  instr_kind_e      kind,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond,
    input  pred_entry_t      top_entry,
    input  logic             full,
    input  logic             empty,
    output logic [LANES-1:0] next_mask,
    output logic             push,
    output logic             pop,
    output pred_entry_t      push_entry,
    output logic             f_skip_then,
    output logic             f_skip_else,
    output logic             f_both,
    output logic             f_ovf,
    output logic             f_err
);
    logic [LANES-1:0] then_lanes;
    logic [LANES-1:0] else_lanes;
    logic [LANES-1:0] alt_lanes;

    // Lanes wanting each side of a new IF, and the ELSE lanes of the open one.
    assign then_lanes = cur_mask & cond;
    assign else_lanes = cur_mask & ~cond;
    assign alt_lanes  = top_entry.parent & ~top_entry.cond;

    // Entry saved when an IF is accepted.
    assign push_entry = '{parent: cur_mask, cond: cond};

    // Select the next mask, the stack action and the flags by class.
    always_comb begin
        next_mask   = cur_mask;
        push        = 1'b0;
        pop         = 1'b0;
        f_skip_then = 1'b0;
        f_skip_else = 1'b0;
        f_both      = 1'b0;
        f_ovf       = 1'b0;
        f_err       = 1'b0;
        if (valid) begin
            unique case (kind)
                KIND_IF: begin
                    if (full) begin
                        f_ovf = 1'b1;
                    end else begin
                        push        = 1'b1;
                        next_mask   = then_lanes;
                        f_skip_then = (then_lanes == '0);
                        f_both      = (then_lanes != '0) && (else_lanes != '0);
                    end
                end
                KIND_ELSE: begin
                    if (empty) begin
                        f_err = 1'b1;
                    end else begin
                        next_mask   = alt_lanes;
                        f_skip_else = (alt_lanes == '0);
                    end
                end
                KIND_ENDIF: begin
                    if (empty) begin
                        f_err = 1'b1;
                    end else begin
                        pop       = 1'b1;
                        next_mask = top_entry.parent;
                    end
                end
                default: begin
                    next_mask = cur_mask;
                end
            endcase
        end
    end

    // R8: the stack is never asked to push past its last slot.
    always_comb begin
        a_r8_no_push_when_full: assert (!(push && full));
    end

    // R9: the stack is never asked to pop when empty.
    always_comb begin
        a_r9_no_pop_when_empty: assert (!(pop && empty));
    end
endmodule

// File: rtl/quad_pred_ctrl.sv
// Quad branch predication controller (top).
// It registers the active-lane mask and the one-cycle flags. The decision
// logic and the predicate stack are kept in submodules. It assumes the
// decoder presents at most one instruction class per cycle.
module quad_pred_ctrl
    import quad_pred_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [1:0]       instr_kind,
    input  logic [LANES-1:0] cond_bits,
    output logic [LANES-1:0] lane_mask,
    output logic             skip_then,
    output logic             skip_else,
    output logic             both_paths,
    output logic             stack_ovf,
    output logic             stack_err
);
    instr_kind_e      kind;
    pred_entry_t      top_entry;
    pred_entry_t      push_entry;
    logic             full;
    logic             empty;
    logic             push;
    logic             pop;
    logic [LANES-1:0] next_mask;
    logic             f_skip_then;
    logic             f_skip_else;
    logic             f_both;
    logic             f_ovf;
    logic             f_err;

    assign kind = instr_kind_e'(instr_kind);

    quad_pred_eval u_eval (
        .valid       (instr_valid),
        .kind        (kind),
        .cur_mask    (lane_mask),
        .cond        (cond_bits),
        .top_entry   (top_entry),
        .full        (full),
        .empty       (empty),
        .next_mask   (next_mask),
        .push        (push),
        .pop         (pop),
        .push_entry  (push_entry),
        .f_skip_then (f_skip_then),
        .f_skip_else (f_skip_else),
        .f_both      (f_both),
        .f_ovf       (f_ovf),
        .f_err       (f_err)
    );

    quad_pred_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_entry (push_entry),
        .top_entry  (top_entry),
        .full       (full),
        .empty      (empty)
    );

    // Register the active-lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_mask <= '1;
        end else begin
            lane_mask <= next_mask;
        end
    end

    // Register the one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_then  <= 1'b0;
            skip_else  <= 1'b0;
            both_paths <= 1'b0;
            stack_ovf  <= 1'b0;
            stack_err  <= 1'b0;
        end else begin
            skip_then  <= f_skip_then;
            skip_else  <= f_skip_else;
            both_paths <= f_both;
            stack_ovf  <= f_ovf;
            stack_err  <= f_err;
        end
    end

    // R2: an accepted IF never wakes a lane.
    a_r2_if_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && kind == KIND_IF && !full)
        |=> ((lane_mask & ~$past(lane_mask)) == '0));

    // R3: a THEN skip request comes with an empty mask.
    a_r3_skip_then_empty: assert property (@(posedge clk) disable iff (!rst_n)
        skip_then |-> (lane_mask == '0));

    // R4: divergence and a THEN skip never coincide.
    a_r4_both_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(both_paths && skip_then));

    // R5: an ELSE skip request comes with an empty mask.
    a_r5_skip_else_empty: assert property (@(posedge clk) disable iff (!rst_n)
        skip_else |-> (lane_mask == '0));

    // R8: a refused IF holds the mask and raises only the overflow flag.
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && kind == KIND_IF && full)
        |=> ($stable(lane_mask) && stack_ovf && !skip_then && !both_paths));

    // R9: a stray ELSE or ENDIF holds the mask and flags an error.
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (kind == KIND_ELSE || kind == KIND_ENDIF) && empty)
        |=> ($stable(lane_mask) && stack_err));

    // R10: idle cycles change nothing.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid || kind == KIND_OTHER)
        |=> ($stable(lane_mask) && !skip_then && !skip_else && !stack_err));
endmodule

// File: tb/quad_pred_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the quad branch predication controller.
// It keeps its own model of the mask and the stack, built from the
// requirements, and compares every output after each operation.
module quad_pred_ctrl_test;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [1:0] instr_kind = 2'b00;
    logic [3:0] cond_bits = 4'h0;
    logic [3:0] lane_mask;
    logic       skip_then, skip_else, both_paths, stack_ovf, stack_err;

    int total = 0;
    int bad   = 0;

    // Model state.
    logic [3:0] m_mask;
    logic [3:0] m_par [D];
    logic [3:0] m_cnd [D];
    int         m_depth;

    always #2.5 clk = ~clk;

    quad_pred_ctrl uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_kind(instr_kind), .cond_bits(cond_bits),
        .lane_mask(lane_mask), .skip_then(skip_then), .skip_else(skip_else),
        .both_paths(both_paths), .stack_ovf(stack_ovf), .stack_err(stack_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one instruction, update the model, check every output.
    task automatic op(input string tag, input logic valid,
                      input logic [1:0] k, input logic [3:0] c);
        logic [3:0] nm;
        logic e_st, e_se, e_bp, e_ov, e_er;
        nm = m_mask; e_st = 0; e_se = 0; e_bp = 0; e_ov = 0; e_er = 0;
        if (valid) begin
            case (k)
                2'b01: if (m_depth == D) e_ov = 1;
                       else begin
                           m_par[m_depth] = m_mask; m_cnd[m_depth] = c;
                           m_depth++;
                           nm = m_mask & c;
                           e_st = (nm == 0);
                           e_bp = (nm != 0) && ((m_mask & ~c) != 0);
                       end
                2'b10: if (m_depth == 0) e_er = 1;
                       else begin
                           nm = m_par[m_depth-1] & ~m_cnd[m_depth-1];
                           e_se = (nm == 0);
                       end
                2'b11: if (m_depth == 0) e_er = 1;
                       else begin
                           nm = m_par[m_depth-1];
                           m_depth--;
                       end
                default: ;
            endcase
        end
        m_mask = nm;
        @(negedge clk);
        instr_valid = valid; instr_kind = k; cond_bits = c;
        @(negedge clk);
        instr_valid = 0; instr_kind = 2'b00; cond_bits = 4'h0;
        check(tag, "lane_mask", lane_mask, m_mask);
        check(tag, "skip_then", {3'b0, skip_then}, {3'b0, e_st});
        check(tag, "skip_else", {3'b0, skip_else}, {3'b0, e_se});
        check(tag, "both_paths", {3'b0, both_paths}, {3'b0, e_bp});
        check(tag, "stack_ovf", {3'b0, stack_ovf}, {3'b0, e_ov});
        check(tag, "stack_err", {3'b0, stack_err}, {3'b0, e_er});
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_mask = 4'hF; m_depth = 0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1", "lane_mask", lane_mask, 4'hF);
        check("R1", "flags", {skip_then, skip_else, both_paths, stack_ovf},
              4'h0);
        check("R1", "stack_err", {3'b0, stack_err}, 4'h0);
    endtask

    // R2 R3 R4 R6: single IF/ENDIF with several condition patterns.
    task automatic t_flat();
        op("R2_R4", 1, 2'b01, 4'b1010);
        op("R6", 1, 2'b11, 4'h0);
        op("R2", 1, 2'b01, 4'hF);
        op("R6", 1, 2'b11, 4'h0);
        op("R3", 1, 2'b01, 4'h0);
        op("R6", 1, 2'b11, 4'h0);
    endtask

    // R5: ELSE with and without a skip.
    task automatic t_else();
        op("R5", 1, 2'b01, 4'b0011);
        op("R5", 1, 2'b10, 4'h0);
        op("R6", 1, 2'b11, 4'h0);
        op("R5", 1, 2'b01, 4'hF);
        op("R5", 1, 2'b10, 4'h0);
        op("R6", 1, 2'b11, 4'h0);
    endtask

    // R2 R7: nesting where inactive lanes must stay inactive.
    task automatic t_nested();
        op("R7", 1, 2'b01, 4'b0110);
        op("R2", 1, 2'b01, 4'b1100);
        op("R5", 1, 2'b10, 4'h0);
        op("R2", 1, 2'b01, 4'b1001);
        op("R7", 1, 2'b11, 4'h0);
        op("R7", 1, 2'b11, 4'h0);
        op("R5", 1, 2'b10, 4'h0);
        op("R7", 1, 2'b11, 4'h0);
    endtask

    // R8 R7: fill the stack, overflow, then unwind all levels.
    task automatic t_overflow();
        for (int i = 0; i < D; i++) begin
            op("R7", 1, 2'b01, (i == 3) ? 4'b1110 : 4'hF);
        end
        op("R8", 1, 2'b01, 4'h0);
        op("R8", 1, 2'b01, 4'b0101);
        for (int i = 0; i < D; i++) begin
            op("R7", 1, 2'b11, 4'h0);
        end
    endtask

    // R9: stray ELSE and ENDIF on an empty stack.
    task automatic t_underflow();
        op("R9", 1, 2'b11, 4'h0);
        op("R9", 1, 2'b10, 4'h0);
    endtask

    // R10: idle and "other" cycles change nothing.
    task automatic t_idle();
        op("R10", 1, 2'b01, 4'b0100);
        op("R10", 0, 2'b01, 4'h0);
        op("R10", 0, 2'b11, 4'hF);
        op("R10", 1, 2'b00, 4'h0);
        op("R10", 1, 2'b11, 4'h0);
    endtask

    // Watchdog.
    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_flat();
        t_else();
        t_nested();
        t_overflow();
        t_underflow();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule